// File: doc/BRIEF.md
# I2C Clock and Data Edge Sequencer

This block produces the SCL waveform and the instants at which SDA may change for a master-side I2C transfer engine. The engine issues one command at a time: a START from an idle bus, a single data bit, a repeated START, or a STOP. The block runs the matching bus sequence and pulses `done` once the sequence is complete. For every data bit it also returns the SDA level it sampled while SCL was high. Between commands SCL is held low, which stretches the bus until the engine issues its next command.

Timing comes from a 32-bit divider word. Bits [15:0] set the SCL low divisor and bits [31:16] set the SCL high divisor. A phase lasts (divisor+1)*8 input clocks. The word is copied into the block only while the bus is idle, so one transfer from START to STOP keeps a single timing set throughout.

States and transitions:
- `S_IDLE`: both lines released. A START command leads to `S_START_HOLD`.
- `S_START_HOLD`: SDA is low and SCL is high for one high period. It then leads to `S_PARK`.
- `S_PARK`: SCL is held low. A bit command leads to `S_BIT_LO`, a repeated START to `S_RS_LO` and a STOP to `S_STOP_LO`.
- `S_BIT_LO`: lasts one low period, then leads to `S_BIT_HI`.
- `S_BIT_HI`: lasts one high period, then returns to `S_PARK`.
- `S_RS_LO`: lasts one low period, then leads to `S_RS_HI`.
- `S_RS_HI`: lasts twice the high period, then returns to `S_PARK`.
- `S_STOP_LO`: lasts one low period, then leads to `S_STOP_HI`.
- `S_STOP_HI`: lasts one high period, then returns to `S_IDLE`.

Let L = (div_low+1)*8 and H = (div_high+1)*8. In the statements below, "cycle k of a phase" counts from 0 at the first clock after the phase begins.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and whenever the block is idle, `scl_o` = 1 and `sda_o` = 1. After reset, `cmd_ready` = 1 and `done` = 0.
- R2: `div_cfg[15:0]` gives the low divisor and `div_cfg[31:16]` gives the high divisor. During a data bit, SCL is low for exactly L clocks and then high for exactly H clocks.
- R3: During a data bit, SDA keeps its previous level for cycles 0 to L/2-1 of the low phase. From cycle L/2 it shows `cmd_bit`, and it stays unchanged while SCL is high.
- R4: `rx_bit` holds the level of `sda_i` sampled at cycle H/2-1 of the high phase of the last data bit. It is valid when `done` is asserted.
- R5: On START (command code 0, accepted only when idle), SDA goes low while SCL stays high for H clocks. SCL then goes low and `done` is asserted.
- R6: On a repeated START (command code 1), SDA is released at cycle L/2 of the low phase. SCL then stays high for 2H clocks. SDA falls after 7H/8 clocks of that high time. SCL then goes low and `done` is asserted.
- R7: On STOP (command code 3), SDA is driven low at cycle L/2 of the low phase. SCL then stays high for H clocks with SDA low. After that, SDA is released, the block becomes idle and `done` is asserted.
- R8: `done` is a one-cycle pulse at the end of each command, and every falling edge of SCL coincides with it. `cmd_ready` is 0 while a command is running.
- R9: The divider word is captured only while idle. A change to `div_cfg` during a transfer does not alter any phase length until the bus has returned to idle.
- R10: An illegal command has no effect: no `done`, no change on SCL or SDA, and `cmd_ready` stays 1. Illegal commands are any non-START command while idle, and START while SCL is parked low. A data bit uses command code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_cfg | input | 32 | Divider word: high divisor in [31:16], low divisor in [15:0] |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 START, 1 repeated START, 2 data bit, 3 STOP |
| cmd_bit | input | 1 | Bit to send on a data-bit command (1 releases SDA) |
| sda_i | input | 1 | Sensed SDA bus level |
| cmd_ready | output | 1 | Block is idle or parked and can accept a command |
| done | output | 1 | One-cycle pulse when a command completes |
| rx_bit | output | 1 | SDA level sampled during the last data bit |
| scl_o | output | 1 | SCL level to drive (1 = released) |
| sda_o | output | 1 | SDA level to drive (1 = released) |

## Verification
The assertions assume the following about the block's inputs:
- `cmd_valid` is only offered while `cmd_ready` is high, or else it is ignored.
- `rst_n` stays low until the clock is running.
- `sda_i` reflects the bus, so it may only be pulled low against a released `sda_o` and never driven high against it.

The bench keeps to these assumptions in three ways:
- It drives SDA as the wired AND of `sda_o` and a modelled target.
- It issues commands only after `done`, except in the deliberate illegal-command cases.
- It draws divisors from 0 to 15, which keeps each phase short enough to exercise many random transfers.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
    typedef enum logic [1:0] {
        OP_START   = 2'd0,
        OP_RESTART = 2'd1,
        OP_BIT     = 2'd2,
        OP_STOP    = 2'd3
    } op_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START_HOLD,
        S_PARK,
        S_BIT_LO,
        S_BIT_HI,
        S_RS_LO,
        S_RS_HI,
        S_STOP_LO,
        S_STOP_HI
    } tg_state_t;
endpackage

// File: rtl/tg_div_latch.sv
module tg_div_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/tg_phase_counter.sv
module tg_phase_counter #(
    parameter int CW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/tg_phase_marks.sv
module tg_phase_marks #(
    parameter int DIVW = 16,
    parameter int CW   = DIVW + 5
) (
    input  logic [DIVW-1:0] div_lo,
    input  logic [DIVW-1:0] div_hi,
    input  logic [CW-1:0]   cnt,
    output logic            lo_half,
    output logic            lo_end,
    output logic            hi_half,
    output logic            hi_78,
    output logic            hi_end,
    output logic            hi2_end
);
    localparam int PADW = CW - DIVW;

    logic [CW-1:0] lo_unit;
    logic [CW-1:0] hi_unit;

    always_comb begin
        // one unit = divisor + 1; phase lengths are multiples of the unit
        lo_unit = {{PADW{1'b0}}, div_lo} + CW'(1);
        hi_unit = {{PADW{1'b0}}, div_hi} + CW'(1);
        lo_half = (cnt == (lo_unit << 2) - CW'(1));
        lo_end  = (cnt == (lo_unit << 3) - CW'(1));
        hi_half = (cnt == (hi_unit << 2) - CW'(1));
        hi_78   = (cnt == (hi_unit * CW'(7)) - CW'(1));
        hi_end  = (cnt == (hi_unit << 3) - CW'(1));
        hi2_end = (cnt == (hi_unit << 4) - CW'(1));
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import i2c_tg_pkg::*;
#(
    parameter int DIVW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*DIVW-1:0] div_cfg,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_bit,
    input  logic              sda_i,
    output logic              cmd_ready,
    output logic              done,
    output logic              rx_bit,
    output logic              scl_o,
    output logic              sda_o
);
    localparam int CW = DIVW + 5;

    tg_state_t       state_q, state_d;
    logic [2*DIVW-1:0] div_q;
    logic [CW-1:0]   cnt;
    logic            phase_clr;
    logic            lo_half, lo_end, hi_half, hi_78, hi_end, hi2_end;
    logic            in_idle, in_park, legal, accept;
    logic            sda_q, tx_q, rx_q, done_q;

    assign in_idle = (state_q == S_IDLE);
    assign in_park = (state_q == S_PARK);
    assign legal   = (in_idle && cmd_op == OP_START) || (in_park && cmd_op != OP_START);
    assign accept  = cmd_valid && legal;

    tg_div_latch #(.W(2*DIVW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .load (in_idle),
        .din  (div_cfg),
        .dout (div_q)
    );

    tg_phase_counter #(.CW(CW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(phase_clr),
        .cnt  (cnt)
    );

    tg_phase_marks #(.DIVW(DIVW), .CW(CW)) u_marks (
        .div_lo (div_q[DIVW-1:0]),
        .div_hi (div_q[2*DIVW-1:DIVW]),
        .cnt    (cnt),
        .lo_half(lo_half),
        .lo_end (lo_end),
        .hi_half(hi_half),
        .hi_78  (hi_78),
        .hi_end (hi_end),
        .hi2_end(hi2_end)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (accept) state_d = S_START_HOLD;
            S_START_HOLD: if (hi_end) state_d = S_PARK;
            S_PARK: begin
                if (accept) begin
                    unique case (op_t'(cmd_op))
                        OP_BIT:     state_d = S_BIT_LO;
                        OP_RESTART: state_d = S_RS_LO;
                        OP_STOP:    state_d = S_STOP_LO;
                        OP_START:   state_d = S_PARK;
                    endcase
                end
            end
            S_BIT_LO:  if (lo_end)  state_d = S_BIT_HI;
            S_BIT_HI:  if (hi_end)  state_d = S_PARK;
            S_RS_LO:   if (lo_end)  state_d = S_RS_HI;
            S_RS_HI:   if (hi2_end) state_d = S_PARK;
            S_STOP_LO: if (lo_end)  state_d = S_STOP_HI;
            S_STOP_HI: if (hi_end)  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
        phase_clr = (state_d != state_q) || in_idle || in_park;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // registered outputs: SDA edges, sampled bit, completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_q  <= 1'b1;
            tx_q   <= 1'b1;
            rx_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (accept) sda_q <= 1'b0;
                end
                S_START_HOLD: begin
                    if (hi_end) done_q <= 1'b1;
                end
                S_PARK: begin
                    if (accept && cmd_op == OP_BIT) tx_q <= cmd_bit;
                end
                S_BIT_LO: begin
                    if (lo_half) sda_q <= tx_q;
                end
                S_BIT_HI: begin
                    if (hi_half) rx_q <= sda_i;
                    if (hi_end)  done_q <= 1'b1;
                end
                S_RS_LO: begin
                    if (lo_half) sda_q <= 1'b1;
                end
                S_RS_HI: begin
                    if (hi_78)   sda_q <= 1'b0;
                    if (hi2_end) done_q <= 1'b1;
                end
                S_STOP_LO: begin
                    if (lo_half) sda_q <= 1'b0;
                end
                S_STOP_HI: begin
                    if (hi_end) begin
                        sda_q  <= 1'b1;
                        done_q <= 1'b1;
                    end
                end
                default: sda_q <= 1'b1;
            endcase
        end
    end

    assign scl_o     = (state_q == S_IDLE) || (state_q == S_START_HOLD) ||
                       (state_q == S_BIT_HI) || (state_q == S_RS_HI) ||
                       (state_q == S_STOP_HI);
    assign sda_o     = sda_q;
    assign cmd_ready = in_idle || in_park;
    assign done      = done_q;
    assign rx_bit    = rx_q;
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk
    import i2c_tg_pkg::*;
#(
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_o,
    input logic            sda_o,
    input logic            done,
    input tg_state_t       st,
    input logic [DW-1:0]   div_q
);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_scl_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> done);

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> (scl_o && sda_o));

    a_r9_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(div_q));

    a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BIT_HI && $past(st) == S_BIT_HI) |-> $stable(sda_o));
endmodule

bind scl_timing_gen scl_timing_gen_chk #(.DW(2*DIVW)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_o(scl_o),
    .sda_o(sda_o),
    .done (done),
    .st   (state_q),
    .div_q(div_q)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
    localparam int MAXREC = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] div_cfg = 32'h0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_bit = 1'b1;
    logic        slave_drv = 1'b1;
    logic        sda_i;
    logic        cmd_ready, done, rx_bit, scl_o, sda_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic rec_scl [MAXREC];
    logic rec_sda [MAXREC];
    int   nrec;
    logic pre_sda;
    logic rdy0;
    int   cur_dl, cur_dh;

    assign sda_i = sda_o & slave_drv;

    always #2.5 clk = ~clk;

    scl_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_bit(cmd_bit), .sda_i(sda_i), .cmd_ready(cmd_ready),
        .done(done), .rx_bit(rx_bit), .scl_o(scl_o), .sda_o(sda_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lo_len(input int d); return (d + 1) * 8; endfunction
    function automatic int hi_len(input int d); return (d + 1) * 8; endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // issue one command and record bus levels until done
    task automatic run_cmd(input logic [1:0] op, input logic b);
        @(negedge clk);
        pre_sda   = sda_o;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_bit   = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        rdy0 = cmd_ready;
        nrec = 0;
        forever begin
            rec_scl[nrec] = scl_o;
            rec_sda[nrec] = sda_o;
            nrec++;
            if (done) break;
            if (nrec >= MAXREC) begin
                chk(1'b0, "R8 command never completed", nrec, 0);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_start(input int dl, input int dh);
        int h = hi_len(dh);
        int good = 0;
        @(negedge clk);
        div_cfg = {16'(dh), 16'(dl)};
        cur_dl = dl; cur_dh = dh;
        run_cmd(2'd0, 1'b0);
        for (int i = 0; i < h && i < nrec; i++) if (rec_scl[i] && !rec_sda[i]) good++;
        chk(nrec == h + 1, "R5 start length", nrec, h + 1);
        chk(good == h, "R5 sda low with scl high", good, h);
        chk(rec_scl[nrec-1] == 1'b0, "R5 scl low at done", int'(rec_scl[nrec-1]), 0);
        chk(rdy0 == 1'b0, "R8 not ready while busy", int'(rdy0), 0);
    endtask

    task automatic do_bit(input logic b, input logic ack);
        int l = lo_len(cur_dl);
        int h = hi_len(cur_dh);
        int ones = 0;
        slave_drv = ack;
        run_cmd(2'd2, b);
        for (int i = 0; i < nrec; i++) if (rec_scl[i]) ones++;
        chk(nrec == l + h + 1, "R2 bit total length", nrec, l + h + 1);
        chk(ones == h, "R2 scl high time", ones, h);
        chk(rec_scl[l-1] == 1'b0 && rec_scl[l] == 1'b1, "R2 scl low time", int'(rec_scl[l]), 1);
        chk(rec_sda[l/2-1] == pre_sda, "R3 sda held first half", int'(rec_sda[l/2-1]), int'(pre_sda));
        chk(rec_sda[l/2] == b, "R3 sda at mid low", int'(rec_sda[l/2]), int'(b));
        chk(rec_sda[l+h-1] == b, "R3 sda steady in high", int'(rec_sda[l+h-1]), int'(b));
        chk(rx_bit == (b & ack), "R4 sampled bit", int'(rx_bit), int'(b & ack));
        slave_drv = 1'b1;
    endtask

    task automatic do_restart();
        int l = lo_len(cur_dl);
        int h = hi_len(cur_dh);
        int s = 7 * (cur_dh + 1);
        int ones = 0;
        run_cmd(2'd1, 1'b0);
        for (int i = 0; i < nrec; i++) if (rec_scl[i]) ones++;
        chk(nrec == l + 2*h + 1, "R6 restart length", nrec, l + 2*h + 1);
        chk(ones == 2*h, "R6 double high time", ones, 2*h);
        chk(rec_sda[l/2] == 1'b1, "R6 sda released mid low", int'(rec_sda[l/2]), 1);
        chk(rec_sda[l+s-1] == 1'b1 && rec_sda[l+s] == 1'b0, "R6 sda falls at 7/8",
            int'(rec_sda[l+s]), 0);
    endtask

    task automatic do_stop();
        int l = lo_len(cur_dl);
        int h = hi_len(cur_dh);
        run_cmd(2'd3, 1'b0);
        chk(nrec == l + h + 1, "R7 stop length", nrec, l + h + 1);
        chk(rec_sda[l/2] == 1'b0, "R7 sda low mid low", int'(rec_sda[l/2]), 0);
        chk(rec_scl[l] == 1'b1 && rec_sda[l+h-1] == 1'b0, "R7 high with sda low",
            int'(rec_sda[l+h-1]), 0);
        chk(rec_scl[l+h] == 1'b1 && rec_sda[l+h] == 1'b1, "R7 released at done",
            int'(rec_sda[l+h]), 1);
        chk(cmd_ready == 1'b1, "R1 idle ready after stop", int'(cmd_ready), 1);
    endtask

    // illegal command: watch for any effect over a window
    task automatic do_illegal(input logic [1:0] op);
        logic s0, d0;
        int moved = 0;
        @(negedge clk);
        s0 = scl_o; d0 = sda_o;
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (scl_o != s0 || sda_o != d0 || done || !cmd_ready) moved++;
            @(negedge clk);
        end
        chk(moved == 0, "R10 illegal command ignored", moved, 0);
    endtask

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(scl_o && sda_o, "R1 lines released in reset", int'({scl_o, sda_o}), 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_o && sda_o && cmd_ready && !done, "R1 reset state",
            int'({scl_o, sda_o, cmd_ready, done}), 4'b1110);

        // directed: smallest divisors, lopsided divisors
        do_start(0, 0);
        do_bit(1'b1, 1'b0);
        do_bit(1'b0, 1'b1);
        do_restart();
        do_bit(1'b1, 1'b1);
        do_stop();

        do_illegal(2'd3);
        do_illegal(2'd2);
        do_start(9, 2);
        do_illegal(2'd0);
        do_bit(1'b0, 1'b1);

        // R9: divider change mid-transfer has no effect until idle
        div_cfg = {16'd14, 16'd13};
        do_bit(1'b1, 1'b1);
        do_restart();
        do_stop();
        do_start(3, 12);
        do_bit(1'b1, 1'b0);
        chk(cur_dl == 3, "R9 new divider after idle", cur_dl, 3);
        do_stop();

        // random transfers
        for (int t = 0; t < 14; t++) begin
            int nb;
            do_start(int'($urandom_range(15)), int'($urandom_range(15)));
            nb = int'($urandom_range(4, 1));
            for (int k = 0; k < nb; k++) begin
                if (k == 1) div_cfg = $urandom;
                do_bit(1'($urandom), 1'($urandom));
            end
            if ($urandom_range(1)) begin
                do_restart();
                do_bit(1'($urandom), 1'($urandom));
            end
            do_stop();
        end

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule